// File: doc/BRIEF.md
# Deep Sleep Entry Arbiter

This block decides which low-power state a chip may actually enter when software asks for deep sleep, and it drives the power controls for that state. Software gives a one-cycle request with a mode of 0, 1 or 2. The arbiter weighs that request against two debug request flags. One flag says a debugger is attached. The other says a debugger wants active memory access. The arbiter then enters an emulated sleep, a core-off sleep, or a sleep with the RC oscillator off, or it refuses the request.

While asleep, the block gathers wake events. External events always count. Timer events count only while the timer clock still runs. Any debugger write also counts as a wake event. On the way back up, the RC oscillator is enabled first, and the core domain is enabled only after the oscillator reports ready. A debugger access that arrives during sleep raises a hold-off output. That output stays high until both the oscillator and the core supply report ready. A 16-bit retention mask chooses which 4 KB RAM banks stay powered in a true deep sleep.

The regulators, oscillators, RAM arrays and debug port sit outside this block. They appear only as enable outputs and ready inputs.

Top module: `deep_sleep_arbiter`

## Requirements
- R1: When the debugger-attached flag is 1 and a request is accepted, the block enters the emulated mode (mode 0), whatever mode was asked for.
- R2: While the memory-access flag is 1, a request made while awake is refused. The refusal is a one-cycle `req_reject` pulse in the following cycle, and the block stays awake with all enables high.
- R3: Modes 1 and 2 are entered only when both debug flags are 0. A request with mode value 3 is always refused. Mode 1 drops `core_pwr_en` and keeps `osc_en` high.
- R4: While asleep in any mode, a debugger write (`dbg_wr_en` high) starts wake-up in the next cycle.
- R5: In mode 2, `osc_en` is 0, and a `timer_wake` pulse is ignored unless `timer_xtal` is 1. In modes 0 and 1, `timer_wake` always wakes the block.
- R6: `ext_wake` starts wake-up from every sleep mode.
- R7: During wake-up, `osc_en` is 1, and `core_pwr_en` is 1 only while `osc_rdy` is 1.
- R8: A debugger write while asleep raises `dbg_holdoff` in the next cycle. It stays high until a cycle in which `osc_rdy` and `core_pwr_rdy` are both 1 while waking or awake, and it falls on the edge after that cycle.
- R9: The retention mask resets to 0xFFFF, and a write replaces it. In modes 1 and 2, `bank_pwr_en[n]` equals mask bit n. In every other state, all bank enables are 1.
- R10: The debug flags are written only by a debugger write, where `dbg_conn` takes `dbg_wr_conn` and `dbg_mem` takes `dbg_wr_mem`, and they are cleared only by `por_n`. The block reset `rst_n` leaves them unchanged.
- R11: In mode 0, `osc_en`, `core_pwr_en` and all bank enables stay 1, and only `sleeping` is raised.
- R12: Wake-up ends in the first cycle in which both ready inputs are 1. The block is then awake in the next cycle, with a one-cycle `wake_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_n | input | 1 | Synchronous active-low power-on reset for the debug flags |
| sleep_req | input | 1 | One-cycle deep sleep request |
| sleep_mode | input | 2 | Requested mode: 0 emulated, 1 core off, 2 RC oscillator off |
| dbg_wr_en | input | 1 | Debugger write strobe for the flags |
| dbg_wr_conn | input | 1 | Value written to the debugger-attached flag |
| dbg_wr_mem | input | 1 | Value written to the memory-access flag |
| timer_xtal | input | 1 | 1 when the timers run from the 32.768 kHz crystal |
| timer_wake | input | 1 | Sleep-timer or watchdog wake event |
| ext_wake | input | 1 | Non-timer wake event |
| osc_rdy | input | 1 | RC oscillator ready |
| core_pwr_rdy | input | 1 | Core domain supply ready |
| retain_wr_en | input | 1 | Retention mask write strobe |
| retain_wr_data | input | 16 | New retention mask |
| osc_en | output | 1 | RC oscillator enable |
| core_pwr_en | output | 1 | Core domain power enable |
| bank_pwr_en | output | 16 | Per-bank RAM power enables |
| dbg_holdoff | output | 1 | Holds off the debugger during wake-up |
| sleeping | output | 1 | High in any sleep state |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| wake_done | output | 1 | One-cycle pulse on return to awake |
| dbg_conn | output | 1 | Debugger-attached flag |
| dbg_mem | output | 1 | Memory-access flag |

## Verification
A wrong state shows up at the ports one edge after the transition that caused it. The possible symptoms are a wrong power enable, a wrong `sleeping` level, or a missing or extra pulse. A wrong latched mode first appears one cycle after entry, when the state moves from entering to sleeping, because mode 0 leaves `core_pwr_en` high where mode 1 or 2 drops it. A stale hold-off or flag value stays visible on its own output until the next release condition. The bench therefore compares every output on every cycle against a behavioural model, so a fault is caught in the first cycle it becomes visible.

// File: rtl/dsa_pkg.sv
// Shared types for the deep sleep arbiter.
// Assumes: states are encoded in three bits; the mode codes are fixed by the software interface.
package dsa_pkg;
    typedef enum logic [2:0] {
        ST_AWAKE = 3'd0,
        ST_ENTER = 3'd1,
        ST_SLP0  = 3'd2,
        ST_SLP1  = 3'd3,
        ST_SLP2  = 3'd4,
        ST_WAKE  = 3'd5
    } pstate_t;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_EMUL    = 2'd0;
    localparam logic [MODE_W-1:0] MODE_CORE    = 2'd1;
    localparam logic [MODE_W-1:0] MODE_RC      = 2'd2;
    localparam logic [MODE_W-1:0] MODE_INVALID = 2'd3;
endpackage

// File: rtl/dsa_dbg_flags.sv
// Holds the two debug request flags.
// Assumes: only the power-on reset or a debugger write may change them; the
// block reset is deliberately not an input here.
module dsa_dbg_flags (
    input  logic clk,
    input  logic por_n,
    input  logic wr_en,
    input  logic wr_conn,
    input  logic wr_mem,
    output logic conn,
    output logic mem
);
    // Flag storage: cleared by power-on reset, loaded by debugger writes.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            conn <= 1'b0;
            mem  <= 1'b0;
        end else if (wr_en) begin
            conn <= wr_conn;
            mem  <= wr_mem;
        end
    end
endmodule

// File: rtl/dsa_retain_mask.sv
// RAM bank retention mask register and the bank power enable decode.
// Assumes: banks are powered while awake; the mask applies only in a true deep sleep.
module dsa_retain_mask #(
    parameter int NUM_BANKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_BANKS-1:0] wr_data,
    input  logic                 true_sleep,
    output logic [NUM_BANKS-1:0] bank_en
);
    localparam logic [NUM_BANKS-1:0] ALL_ON = {NUM_BANKS{1'b1}};

    logic [NUM_BANKS-1:0] mask_q;

    // Mask register: all banks retained after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= ALL_ON;
        else if (wr_en)
            mask_q <= wr_data;
    end

    // Per-bank enable: the mask bit in true sleep, otherwise powered.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_en[b] = true_sleep ? mask_q[b] : 1'b1;
    end
endmodule

// File: rtl/dsa_wake_collect.sv
// Combines the wake sources that are valid in the current sleep state.
// Assumes: timer events need the RC oscillator unless the crystal clocks the timers.
module dsa_wake_collect
    import dsa_pkg::*;
(
    input  pstate_t state,
    input  logic    timer_wake,
    input  logic    timer_xtal,
    input  logic    ext_wake,
    input  logic    dbg_access,
    output logic    wake_evt
);
    logic timer_ok;

    // Timer validity: the RC oscillator is off only in mode 2.
    always_comb begin
        timer_ok = timer_wake && ((state != ST_SLP2) || timer_xtal);
        wake_evt = ext_wake || dbg_access || timer_ok;
    end
endmodule

// File: rtl/dsa_fsm.sv
// Sleep state sequencer: accepts or refuses requests, holds the sleep state,
// and leaves wake-up when both ready inputs are true.
// Assumes: sleep_req is sampled only while awake; wake_evt is already qualified.
module dsa_fsm
    import dsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [MODE_W-1:0] sleep_mode,
    input  logic              dbg_conn,
    input  logic              dbg_mem,
    input  logic              wake_evt,
    input  logic              both_rdy,
    output pstate_t           state,
    output logic [MODE_W-1:0] tgt_mode,
    output logic              req_reject,
    output logic              wake_done
);
    pstate_t           nxt;
    logic [MODE_W-1:0] nxt_mode;
    logic              refuse;

    // Next-state decision from the current state, the request and the flags.
    always_comb begin
        nxt      = state;
        nxt_mode = tgt_mode;
        refuse   = 1'b0;
        unique case (state)
            ST_AWAKE: if (sleep_req) begin
                if (dbg_mem || sleep_mode == MODE_INVALID) begin
                    refuse = 1'b1;
                end else begin
                    nxt      = ST_ENTER;
                    nxt_mode = dbg_conn ? MODE_EMUL : sleep_mode;
                end
            end
            ST_ENTER: begin
                if (tgt_mode == MODE_EMUL)      nxt = ST_SLP0;
                else if (tgt_mode == MODE_CORE) nxt = ST_SLP1;
                else                            nxt = ST_SLP2;
            end
            ST_SLP0, ST_SLP1, ST_SLP2: if (wake_evt) nxt = ST_WAKE;
            ST_WAKE: if (both_rdy) nxt = ST_AWAKE;
            default: nxt = ST_AWAKE;
        endcase
    end

    // State, latched mode and the two pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_AWAKE;
            tgt_mode   <= MODE_EMUL;
            req_reject <= 1'b0;
            wake_done  <= 1'b0;
        end else begin
            state      <= nxt;
            tgt_mode   <= nxt_mode;
            req_reject <= refuse;
            wake_done  <= (state == ST_WAKE) && both_rdy;
        end
    end
endmodule

// File: rtl/deep_sleep_arbiter.sv
// Top of the deep sleep arbiter: flags, wake collection, sequencer, retention
// mask and the power control decode.
// Assumes: ready inputs come from the external regulator and oscillator.
module deep_sleep_arbiter
    import dsa_pkg::*;
#(
    parameter int NUM_BANKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 por_n,
    input  logic                 sleep_req,
    input  logic [1:0]           sleep_mode,
    input  logic                 dbg_wr_en,
    input  logic                 dbg_wr_conn,
    input  logic                 dbg_wr_mem,
    input  logic                 timer_xtal,
    input  logic                 timer_wake,
    input  logic                 ext_wake,
    input  logic                 osc_rdy,
    input  logic                 core_pwr_rdy,
    input  logic                 retain_wr_en,
    input  logic [NUM_BANKS-1:0] retain_wr_data,
    output logic                 osc_en,
    output logic                 core_pwr_en,
    output logic [NUM_BANKS-1:0] bank_pwr_en,
    output logic                 dbg_holdoff,
    output logic                 sleeping,
    output logic                 req_reject,
    output logic                 wake_done,
    output logic                 dbg_conn,
    output logic                 dbg_mem
);
    pstate_t           state;
    logic [MODE_W-1:0] tgt_mode;
    logic              wake_evt;
    logic              both_rdy;
    logic              true_sleep;

    assign both_rdy   = osc_rdy && core_pwr_rdy;
    assign true_sleep = (state == ST_SLP1) || (state == ST_SLP2);

    dsa_dbg_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (dbg_wr_en),
        .wr_conn (dbg_wr_conn),
        .wr_mem  (dbg_wr_mem),
        .conn    (dbg_conn),
        .mem     (dbg_mem)
    );

    dsa_wake_collect u_wake (
        .state      (state),
        .timer_wake (timer_wake),
        .timer_xtal (timer_xtal),
        .ext_wake   (ext_wake),
        .dbg_access (dbg_wr_en),
        .wake_evt   (wake_evt)
    );

    dsa_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .sleep_mode (sleep_mode),
        .dbg_conn   (dbg_conn),
        .dbg_mem    (dbg_mem),
        .wake_evt   (wake_evt),
        .both_rdy   (both_rdy),
        .state      (state),
        .tgt_mode   (tgt_mode),
        .req_reject (req_reject),
        .wake_done  (wake_done)
    );

    dsa_retain_mask #(.NUM_BANKS(NUM_BANKS)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (retain_wr_en),
        .wr_data    (retain_wr_data),
        .true_sleep (true_sleep),
        .bank_en    (bank_pwr_en)
    );

    // Power decode: oscillator off only in mode 2; core gated behind oscillator on wake.
    always_comb begin
        sleeping = (state == ST_SLP0) || true_sleep;
        osc_en   = (state != ST_SLP2);
        unique case (state)
            ST_SLP1, ST_SLP2: core_pwr_en = 1'b0;
            ST_WAKE:          core_pwr_en = osc_rdy;
            default:          core_pwr_en = 1'b1;
        endcase
    end

    // Debugger hold-off: set by an access during sleep, released once both supplies are ready.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbg_holdoff <= 1'b0;
        else if (sleeping && dbg_wr_en)
            dbg_holdoff <= 1'b1;
        else if ((state == ST_WAKE || state == ST_AWAKE) && both_rdy)
            dbg_holdoff <= 1'b0;
    end
endmodule

// File: rtl/dsa_checker.sv
// Property checker for the deep sleep arbiter, bound to every instance.
module dsa_checker
    import dsa_pkg::*;
#(
    parameter int NUM_BANKS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sleep_req,
    input logic [1:0]           sleep_mode,
    input logic                 dbg_conn,
    input logic                 dbg_mem,
    input logic                 osc_en,
    input logic                 osc_rdy,
    input logic                 core_pwr_en,
    input logic                 core_pwr_rdy,
    input logic                 dbg_holdoff,
    input logic                 sleeping,
    input logic                 req_reject,
    input logic                 wake_done,
    input logic [NUM_BANKS-1:0] bank_pwr_en,
    input pstate_t              state,
    input logic [1:0]           tgt_mode
);
    AST_CONN_FORCES_EMUL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && sleep_req && dbg_conn && !dbg_mem && sleep_mode != MODE_INVALID)
        |=> (state == ST_ENTER && tgt_mode == MODE_EMUL)); // R1

    AST_MEM_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && sleep_req && dbg_mem) |=> (req_reject && state == ST_AWAKE)); // R2

    AST_OSC_OFF_ONLY_MODE2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (state == ST_SLP2)); // R5

    AST_CORE_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && core_pwr_en) |-> osc_rdy); // R7

    AST_HOLDOFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dbg_holdoff) |-> $past(osc_rdy && core_pwr_rdy)); // R8

    AST_BANKS_ON_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !sleeping |-> (&bank_pwr_en)); // R9

    AST_DONE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> (state == ST_AWAKE && $past(state == ST_WAKE))); // R12
endmodule

bind deep_sleep_arbiter dsa_checker #(.NUM_BANKS(NUM_BANKS)) u_dsa_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .sleep_mode   (sleep_mode),
    .dbg_conn     (dbg_conn),
    .dbg_mem      (dbg_mem),
    .osc_en       (osc_en),
    .osc_rdy      (osc_rdy),
    .core_pwr_en  (core_pwr_en),
    .core_pwr_rdy (core_pwr_rdy),
    .dbg_holdoff  (dbg_holdoff),
    .sleeping     (sleeping),
    .req_reject   (req_reject),
    .wake_done    (wake_done),
    .bank_pwr_en  (bank_pwr_en),
    .state        (state),
    .tgt_mode     (tgt_mode)
);

// File: tb/deep_sleep_arbiter_bench.sv
module deep_sleep_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        sleep_req = 1'b0;
    logic [1:0]  sleep_mode = 2'd0;
    logic        dbg_wr_en = 1'b0, dbg_wr_conn = 1'b0, dbg_wr_mem = 1'b0;
    logic        timer_xtal = 1'b0, timer_wake = 1'b0, ext_wake = 1'b0;
    logic        osc_rdy = 1'b1, core_pwr_rdy = 1'b1;
    logic        retain_wr_en = 1'b0;
    logic [15:0] retain_wr_data = 16'h0;
    logic        osc_en, core_pwr_en, dbg_holdoff, sleeping, req_reject, wake_done;
    logic        dbg_conn, dbg_mem;
    logic [15:0] bank_pwr_en;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    deep_sleep_arbiter u_deep_sleep_arbiter (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .sleep_req(sleep_req),
        .sleep_mode(sleep_mode), .dbg_wr_en(dbg_wr_en), .dbg_wr_conn(dbg_wr_conn),
        .dbg_wr_mem(dbg_wr_mem), .timer_xtal(timer_xtal), .timer_wake(timer_wake),
        .ext_wake(ext_wake), .osc_rdy(osc_rdy), .core_pwr_rdy(core_pwr_rdy),
        .retain_wr_en(retain_wr_en), .retain_wr_data(retain_wr_data),
        .osc_en(osc_en), .core_pwr_en(core_pwr_en), .bank_pwr_en(bank_pwr_en),
        .dbg_holdoff(dbg_holdoff), .sleeping(sleeping), .req_reject(req_reject),
        .wake_done(wake_done), .dbg_conn(dbg_conn), .dbg_mem(dbg_mem)
    );

    // Behavioural reference: 0 awake, 1 entering, 2..4 sleep in mode 0..2, 5 waking.
    int          m_st = 0;
    int          m_mode = 0;
    bit          m_conn = 0, m_mem = 0, m_hold = 0, m_rej = 0, m_done = 0;
    logic [15:0] m_mask = 16'hFFFF;

    always @(posedge clk) begin
        bit asleep, rdy, wake;
        asleep = (m_st >= 2 && m_st <= 4);
        rdy    = osc_rdy && core_pwr_rdy;
        if (!rst_n) begin
            m_st = 0; m_mask = 16'hFFFF; m_hold = 0; m_rej = 0; m_done = 0;
        end else begin
            m_rej = 0; m_done = 0;
            if (asleep && dbg_wr_en) m_hold = 1;
            else if ((m_st == 5 || m_st == 0) && rdy) m_hold = 0;
            wake = ext_wake || dbg_wr_en || (timer_wake && (m_st != 4 || timer_xtal));
            if (m_st == 0) begin
                if (sleep_req) begin
                    if (m_mem || sleep_mode == 2'd3) m_rej = 1;
                    else begin m_mode = m_conn ? 0 : int'(sleep_mode); m_st = 1; end
                end
            end else if (m_st == 1) m_st = 2 + m_mode;
            else if (asleep) begin
                if (wake) m_st = 5;
            end else if (m_st == 5 && rdy) begin
                m_st = 0; m_done = 1;
            end
            if (retain_wr_en) m_mask = retain_wr_data;
        end
        if (!por_n) begin m_conn = 0; m_mem = 0; end
        else if (dbg_wr_en) begin m_conn = dbg_wr_conn; m_mem = dbg_wr_mem; end
    end

    task automatic expect_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Full port comparison against the model.
    task automatic compare();
        bit sl;
        sl = (m_st >= 2 && m_st <= 4);
        expect_eq("R5 osc_en", {15'b0, osc_en}, {15'b0, m_st != 4});
        expect_eq("R7 core_pwr_en", {15'b0, core_pwr_en},
                  {15'b0, (m_st == 3 || m_st == 4) ? 1'b0 : (m_st == 5 ? osc_rdy : 1'b1)});
        expect_eq("R9 bank_pwr_en", bank_pwr_en, (m_st == 3 || m_st == 4) ? m_mask : 16'hFFFF);
        expect_eq("R11 sleeping", {15'b0, sleeping}, {15'b0, sl});
        expect_eq("R2 req_reject", {15'b0, req_reject}, {15'b0, m_rej});
        expect_eq("R12 wake_done", {15'b0, wake_done}, {15'b0, m_done});
        expect_eq("R8 dbg_holdoff", {15'b0, dbg_holdoff}, {15'b0, m_hold});
        expect_eq("R10 flags", {14'b0, dbg_conn, dbg_mem}, {14'b0, m_conn, m_mem});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic request(input logic [1:0] mode);
        sleep_req = 1'b1; sleep_mode = mode; step();
        sleep_req = 1'b0; step();
    endtask

    task automatic dbg_write(input logic c, input logic m);
        dbg_wr_en = 1'b1; dbg_wr_conn = c; dbg_wr_mem = m; step();
        dbg_wr_en = 1'b0;
    endtask

    task automatic pulse_ext();
        ext_wake = 1'b1; step(); ext_wake = 1'b0;
    endtask

    task automatic ready_up();
        osc_rdy = 1'b1; core_pwr_rdy = 1'b1; step(); step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1; por_n = 1'b1; step();
        expect_eq("R9 reset mask all on", bank_pwr_en, 16'hFFFF);

        retain_wr_en = 1'b1; retain_wr_data = 16'hA5C3; step(); retain_wr_en = 1'b0;

        // Mode 1 with staged ready inputs.
        request(2'd1);
        expect_eq("R3 mode1 core off", {15'b0, core_pwr_en}, 16'h0);
        expect_eq("R9 mode1 mask", bank_pwr_en, 16'hA5C3);
        osc_rdy = 1'b0; core_pwr_rdy = 1'b0;
        pulse_ext();
        expect_eq("R7 osc on during wake", {15'b0, osc_en}, 16'h1);
        expect_eq("R7 core held before osc", {15'b0, core_pwr_en}, 16'h0);
        osc_rdy = 1'b1; step();
        core_pwr_rdy = 1'b1; step();
        expect_eq("R12 wake_done pulse", {15'b0, wake_done}, 16'h1);
        step();

        // Mode 2, timers on RC: timer event ignored.
        request(2'd2);
        expect_eq("R5 osc off in mode2", {15'b0, osc_en}, 16'h0);
        osc_rdy = 1'b0; core_pwr_rdy = 1'b0;
        timer_wake = 1'b1; step(); timer_wake = 1'b0;
        expect_eq("R5 timer ignored", {15'b0, sleeping}, 16'h1);
        pulse_ext();
        expect_eq("R6 ext wake mode2", {15'b0, sleeping}, 16'h0);
        ready_up();

        // Mode 2, timers on crystal: timer event wakes.
        timer_xtal = 1'b1;
        request(2'd2);
        osc_rdy = 1'b0; core_pwr_rdy = 1'b0;
        timer_wake = 1'b1; step(); timer_wake = 1'b0;
        expect_eq("R5 crystal timer wakes", {15'b0, sleeping}, 16'h0);
        ready_up();
        timer_xtal = 1'b0;

        // Mode 1 timer wake without crystal.
        request(2'd1);
        timer_wake = 1'b1; step(); timer_wake = 1'b0;
        expect_eq("R5 mode1 timer wakes", {15'b0, sleeping}, 16'h0);
        step(); step();

        // Mode 0 requested directly.
        request(2'd0);
        expect_eq("R11 mode0 core on", {15'b0, core_pwr_en}, 16'h1);
        expect_eq("R11 mode0 sleeping", {15'b0, sleeping}, 16'h1);
        pulse_ext();
        expect_eq("R6 ext wake mode0", {15'b0, sleeping}, 16'h0);
        step(); step();

        // Debugger attached: mode 2 request forced to mode 0.
        dbg_write(1'b1, 1'b0); step();
        request(2'd2);
        expect_eq("R1 forced emulated", {15'b0, core_pwr_en}, 16'h1);
        expect_eq("R1 osc kept on", {15'b0, osc_en}, 16'h1);
        osc_rdy = 1'b0; core_pwr_rdy = 1'b0;
        dbg_write(1'b1, 1'b0);
        expect_eq("R4 debugger wakes", {15'b0, sleeping}, 16'h0);
        expect_eq("R8 holdoff raised", {15'b0, dbg_holdoff}, 16'h1);
        step();
        expect_eq("R8 holdoff held", {15'b0, dbg_holdoff}, 16'h1);
        osc_rdy = 1'b1; core_pwr_rdy = 1'b1; step();
        expect_eq("R8 holdoff released", {15'b0, dbg_holdoff}, 16'h0);
        step();

        // Memory-access flag refuses entry.
        dbg_write(1'b0, 1'b1); step();
        sleep_req = 1'b1; sleep_mode = 2'd1; step(); sleep_req = 1'b0;
        expect_eq("R2 reject pulse", {15'b0, req_reject}, 16'h1);
        expect_eq("R2 stays awake", {15'b0, sleeping}, 16'h0);
        step(); step();
        expect_eq("R2 still awake", {15'b0, core_pwr_en}, 16'h1);

        // Invalid mode 3 refused with flags clear.
        dbg_write(1'b0, 1'b0); step();
        sleep_req = 1'b1; sleep_mode = 2'd3; step(); sleep_req = 1'b0;
        expect_eq("R3 mode3 rejected", {15'b0, req_reject}, 16'h1);
        step();

        // Block reset keeps flags, power-on reset clears them.
        dbg_write(1'b1, 1'b0);
        retain_wr_en = 1'b1; retain_wr_data = 16'h0F0F; step(); retain_wr_en = 1'b0;
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        expect_eq("R10 flag kept over rst_n", {15'b0, dbg_conn}, 16'h1);
        por_n = 1'b0; step(); por_n = 1'b1; step();
        expect_eq("R10 flag cleared by por_n", {15'b0, dbg_conn}, 16'h0);
        request(2'd1);
        expect_eq("R9 mask back to all on", bank_pwr_en, 16'hFFFF);
        pulse_ext(); step(); step();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule